// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for an out-of-order core. Issue logic claims one entry per cycle, in program order. Each entry records the destination register and whether the instruction is a branch. The entry's index goes back to the issue logic as the tag that the instruction's result will carry.

Functional units send results back on a shared result bus, in any order. Each result carries its tag, its value and a fault flag, where a fault means a mispredicted branch or an exception. A result goes into its buffer entry, not into the register file. Issue logic can read it from the entry through a lookup port before it retires.

Retirement runs strictly in allocation order. Each cycle, the oldest entry is examined:
- If it is finished and clean, it retires on the register-file write port.
- If it is finished and faulted, the whole buffer is discarded so that execution can restart from a clean state.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `allocReady`=1, `allocTag`=0, `commitValid`=0, `flush`=0 and `lookupReady`=0 for every tag.
- R2: Allocations receive consecutive tags in program order. Tags count up by one and wrap from DEPTH-1 to 0. DEPTH must be a power of two.
- R3: `allocReady` is low while DEPTH entries are outstanding. An allocation request made while `allocReady` is low is ignored and leaves `allocTag` unchanged.
- R4: A result whose tag names an entry that is not allocated is ignored. That tag's `lookupReady` stays 0, and when the tag is allocated later the entry starts out incomplete.
- R5: For an allocated entry that has received its result, `lookupReady`=1 and `lookupValue` is the last value written to it. For an allocated entry still waiting, `lookupReady`=0.
- R6: At most one entry retires per cycle. Only the oldest entry may retire, and only once its result has arrived without a fault. Retirement therefore follows allocation order even when results arrive out of order.
- R7: While `commitValid`=1, `commitDest` and `commitValue` hold the oldest entry's destination register and result value.
- R8: When the oldest entry has completed with its fault flag set (`resFault`=1):
  - `flush`=1 and `commitValid`=0 in that cycle;
  - `flushBranch` equals that entry's branch flag;
  - `allocReady` is 0 in that cycle;
  - at the next edge every entry is discarded and the next tag handed out is 0.
- R9: A retired entry is freed. Its `lookupReady` reads 0 until it is allocated again and completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Request to claim an entry this cycle |
| allocDest | input | REG_W | Destination register of the new instruction |
| allocIsBranch | input | 1 | New instruction is a branch |
| allocReady | output | 1 | An entry can be claimed this cycle |
| allocTag | output | IDX_W | Tag given to the instruction allocating this cycle |
| resValid | input | 1 | Result bus carries a result |
| resTag | input | IDX_W | Entry the result belongs to |
| resValue | input | DATA_W | Result value |
| resFault | input | 1 | Result marks a mispredict or an exception |
| commitValid | output | 1 | Register-file write of the oldest entry this cycle |
| commitDest | output | REG_W | Register written |
| commitValue | output | DATA_W | Value written |
| flush | output | 1 | Oldest entry faulted; all entries discarded at the edge |
| flushBranch | output | 1 | Faulting entry was a branch |
| lookupTag | input | IDX_W | Entry queried by issue logic |
| lookupReady | output | 1 | Queried entry is allocated and has its result |
| lookupValue | output | DATA_W | Result held by the queried entry |

## Verification
The assertions assume the following about the environment:
- It only raises `allocValid` as a request and treats it as accepted only when `allocReady` is high.
- It never retracts an outstanding tag except through a flush.
- It sends results for any tag at any time. The tag-order and occupancy properties hold only because ignored results and refused allocations leave no trace.

The stimulus keeps within these assumptions and tests them:
- Random result tags are drawn across the whole index range, so many of them hit unallocated entries.
- Random allocation requests keep arriving while the buffer is full.
- Faults are rare, so the buffer spends long stretches near full before a flush empties it.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic alloc;   // claim the entry at the tail
    logic commit;  // retire the entry at the head
    logic flush;   // discard every entry
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             headDone,
  input  logic             headFault,
  output logic             allocReady,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output robStrobe_t       strobe
);

  logic [PTR_W-1:0] headPtr, tailPtr;
  logic isEmpty, isFull, headReady;

  // Extra top bit tells full from empty when the indices match.
  assign isEmpty   = (headPtr == tailPtr);
  assign isFull    = (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]) &&
                     (headPtr[IDX_W] != tailPtr[IDX_W]);
  assign headReady = !isEmpty && headDone;

  assign strobe.flush  = headReady && headFault;
  assign strobe.commit = headReady && !headFault;
  assign allocReady    = !isFull && !strobe.flush;
  assign strobe.alloc  = allocValid && allocReady;

  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobe.flush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.commit) headPtr <= headPtr + 1'b1;
      if (strobe.alloc)  tailPtr <= tailPtr + 1'b1;
    end
  end

endmodule

// File: rtl/rob_dpath.sv
module rob_dpath
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [REG_W-1:0]  allocDest,
  input  logic              allocIsBranch,
  input  logic              resValid,
  input  logic [IDX_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resValue,
  input  logic              resFault,
  input  logic [IDX_W-1:0]  lookupTag,
  output logic              headDone,
  output logic              headFault,
  output logic              headBranch,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue
);

  logic [DEPTH-1:0]  entValid, entDone, entFault, entBranch;
  logic [REG_W-1:0]  entDest  [DEPTH];
  logic [DATA_W-1:0] entValue [DEPTH];
  logic resHit;

  // Results for entries that are not allocated are dropped.
  assign resHit = resValid && entValid[resTag];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entDone  <= '0;
      entFault <= '0;
    end else if (strobe.flush) begin
      entValid <= '0;
      entDone  <= '0;
      entFault <= '0;
    end else begin
      if (resHit) begin
        entDone[resTag]  <= 1'b1;
        entFault[resTag] <= resFault;
      end
      if (strobe.commit) entValid[headIdx] <= 1'b0;
      if (strobe.alloc) begin
        entValid[tailIdx] <= 1'b1;
        entDone[tailIdx]  <= 1'b0;
        entFault[tailIdx] <= 1'b0;
      end
    end
  end

  // Payload storage needs no reset: it is qualified by the valid/done bits.
  always_ff @(posedge clk) begin
    if (resHit) entValue[resTag] <= resValue;
    if (strobe.alloc) begin
      entDest[tailIdx]   <= allocDest;
      entBranch[tailIdx] <= allocIsBranch;
    end
  end

  assign headDone    = entDone[headIdx];
  assign headFault   = entFault[headIdx];
  assign headBranch  = entBranch[headIdx];
  assign headDest    = entDest[headIdx];
  assign headValue   = entValue[headIdx];
  assign lookupReady = entValid[lookupTag] && entDone[lookupTag];
  assign lookupValue = entValue[lookupTag];

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocDest,
  input  logic              allocIsBranch,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocTag,
  input  logic              resValid,
  input  logic [IDX_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resValue,
  input  logic              resFault,
  output logic              commitValid,
  output logic [REG_W-1:0]  commitDest,
  output logic [DATA_W-1:0] commitValue,
  output logic              flush,
  output logic              flushBranch,
  input  logic [IDX_W-1:0]  lookupTag,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue
);

  robStrobe_t       strobe;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             headDone, headFault, headBranch;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .headDone   (headDone),
    .headFault  (headFault),
    .allocReady (allocReady),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .strobe     (strobe)
  );

  rob_dpath #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .headIdx       (headIdx),
    .tailIdx       (tailIdx),
    .allocDest     (allocDest),
    .allocIsBranch (allocIsBranch),
    .resValid      (resValid),
    .resTag        (resTag),
    .resValue      (resValue),
    .resFault      (resFault),
    .lookupTag     (lookupTag),
    .headDone      (headDone),
    .headFault     (headFault),
    .headBranch    (headBranch),
    .headDest      (commitDest),
    .headValue     (commitValue),
    .lookupReady   (lookupReady),
    .lookupValue   (lookupValue)
  );

  assign allocTag    = tailIdx;
  assign commitValid = strobe.commit;
  assign flush       = strobe.flush;
  assign flushBranch = strobe.flush && headBranch;

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocTag,
  input logic             commitValid,
  input logic             flush
);

  // Occupancy rebuilt from port activity only.
  logic [IDX_W:0] occ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      occ <= '0;
    else if (flush) occ <= '0;
    else            occ <= occ + (IDX_W+1)'(allocValid && allocReady)
                               - (IDX_W+1)'(commitValid);
  end

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> (allocReady == (occ != (IDX_W+1)'(DEPTH))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= (IDX_W+1)'(DEPTH));

  assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady) |=> allocTag == IDX_W'($past(allocTag) + 1'b1));

  assert_no_commit_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> occ != '0);

  assert_flush_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(flush && (commitValid || allocReady)));

  assert_flush_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (allocTag == '0) && allocReady && !commitValid && !flush);

endmodule

bind reorder_buf rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .allocValid  (allocValid),
  .allocReady  (allocReady),
  .allocTag    (allocTag),
  .commitValid (commitValid),
  .flush       (flush)
);

// File: tb/tb_reorder_buf.sv
`timescale 1ns/1ps
module tb_reorder_buf;

  localparam int DEPTH = 8;
  localparam int IW    = 3;
  localparam int RW    = 5;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0, allocIsBranch = 1'b0;
  logic [RW-1:0] allocDest = '0;
  logic allocReady;
  logic [IW-1:0] allocTag;
  logic resValid = 1'b0, resFault = 1'b0;
  logic [IW-1:0] resTag = '0;
  logic [DW-1:0] resValue = '0;
  logic commitValid, flush, flushBranch, lookupReady;
  logic [RW-1:0] commitDest;
  logic [DW-1:0] commitValue, lookupValue;
  logic [IW-1:0] lookupTag = '0;

  always #2.5 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .REG_W(RW), .DATA_W(DW)) dut (.*);

  int nTests = 0, nFail = 0;
  bit finished = 1'b0;

  // Reference model state
  bit mV[DEPTH], mD[DEPTH], mF[DEPTH], mB[DEPTH];
  logic [DW-1:0] mVal[DEPTH];
  logic [RW-1:0] mDst[DEPTH];
  int mHead = 0, mTail = 0, mCnt = 0;

  function automatic bit expHeadReady();
    return (mCnt > 0) && mD[mHead];
  endfunction

  function automatic bit expLookupReady(int t);
    return mV[t] && mD[t];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic step(bit a, logic [RW-1:0] d, bit br,
                      bit r, int rt, logic [DW-1:0] rv, bit rf, int lt);
    bit hr, eFlush, eCommit, eReady, rOk;
    @(negedge clk);
    allocValid = a; allocDest = d; allocIsBranch = br;
    resValid = r; resTag = IW'(rt); resValue = rv; resFault = rf;
    lookupTag = IW'(lt);
    #1;
    hr      = expHeadReady();
    eFlush  = hr && mF[mHead];
    eCommit = hr && !mF[mHead];
    eReady  = (mCnt < DEPTH) && !eFlush;
    chk(allocTag == IW'(mTail), "R2 tag", allocTag, mTail);
    chk(allocReady == eReady, "R3 ready", allocReady, eReady);
    chk(flush == eFlush, "R8 flush", flush, eFlush);
    if (eFlush) chk(flushBranch == mB[mHead], "R8 branch", flushBranch, mB[mHead]);
    chk(commitValid == eCommit, "R6 commit", commitValid, eCommit);
    if (eCommit) begin
      chk(commitDest == mDst[mHead], "R7 dest", commitDest, mDst[mHead]);
      chk(commitValue == mVal[mHead], "R7 value", commitValue, mVal[mHead]);
    end
    chk(lookupReady == expLookupReady(lt), "R5 R4 R9 lookup ready",
        lookupReady, expLookupReady(lt));
    if (expLookupReady(lt)) chk(lookupValue == mVal[lt], "R5 lookup value",
                                lookupValue, mVal[lt]);
    @(posedge clk);
    rOk = r && mV[rt];
    if (rOk) begin mD[rt] = 1; mF[rt] = rf; mVal[rt] = rv; end
    if (eCommit) begin
      mV[mHead] = 0; mD[mHead] = 0;
      mHead = (mHead + 1) % DEPTH; mCnt--;
    end
    if (a && eReady) begin
      mV[mTail] = 1; mD[mTail] = 0; mF[mTail] = 0;
      mB[mTail] = br; mDst[mTail] = d;
      mTail = (mTail + 1) % DEPTH; mCnt++;
    end
    if (eFlush) begin
      for (int i = 0; i < DEPTH; i++) begin mV[i] = 0; mD[i] = 0; mF[i] = 0; end
      mHead = 0; mTail = 0; mCnt = 0;
    end
  endtask

  task automatic idle(int lt);
    step(0, '0, 0, 0, 0, '0, 0, lt);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    // R1: empty after reset
    chk(allocReady == 1'b1, "R1 ready", allocReady, 1);
    chk(allocTag == '0, "R1 tag", allocTag, 0);
    chk(commitValid == 1'b0, "R1 commit", commitValid, 0);
    chk(flush == 1'b0, "R1 flush", flush, 0);
    for (int t = 0; t < DEPTH; t++) begin
      lookupTag = IW'(t); #0.1;
      chk(lookupReady == 1'b0, "R1 lookup", lookupReady, 0);
    end

    // R4: result to unallocated tag 2 ignored, then tag 2 allocated incomplete
    step(0, '0, 0, 1, 2, 32'hDEAD, 0, 2);
    idle(2);
    // R3: fill, then request while full
    for (int i = 0; i < DEPTH; i++) step(1, RW'(i + 1), 0, 0, 0, '0, 0, 2);
    step(1, 5'd31, 0, 0, 0, '0, 0, 2);
    step(1, 5'd30, 0, 0, 0, '0, 0, 2);
    // R6: out-of-order completion 3,1,2,0
    step(0, '0, 0, 1, 3, 32'h33, 0, 3);
    step(0, '0, 0, 1, 1, 32'h11, 0, 1);
    step(0, '0, 0, 1, 2, 32'h22, 0, 2);
    step(0, '0, 0, 1, 0, 32'h00, 0, 0);
    for (int i = 0; i < 6; i++) idle(i % DEPTH);   // R9: freed entries read not-ready
    // R8: faulting branch at head
    step(1, 5'd7, 1, 0, 0, '0, 0, 0);
    for (int i = 0; i < DEPTH; i++) step(0, '0, 0, 1, i, 32'(i * 3), 0, i);
    step(0, '0, 0, 1, mHead, 32'hBAD, 1, mHead);
    idle(0); idle(0); idle(0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 6, RW'($urandom), $urandom % 2,
           ($urandom % 4) != 0, (mHead + ($urandom % DEPTH)) % DEPTH,
           $urandom, ($urandom % 24) == 0, $urandom % DEPTH);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule